// File: doc/BRIEF.md
# SCL Timing Generator with Prescaler Divider Encoding

This block turns a requested ratio of peripheral clock to I2C bus clock into a packed 32-bit timing control word. It then runs an SCL low/high phase sequencer from that word. The ratio is split into two parts: a power-of-two prescaler exponent, and a mantissa below sixteen that is rounded up whenever bits are discarded. The mantissa is then divided unevenly into a low-phase count and a high-phase count. All other timing fields of the word take fixed constant values.

A transfer engine pulses `start` with the ratio and a high-speed selection applied. One cycle later the encoded word is available. From then on, `scl_low` marks the low phase of the bus clock, and `phase_tick` pulses in the first cycle of each new phase. This continues until `stop` is pulsed. Between accepted strobes the word is held, so changing the inputs has no effect on it.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, `timing_word` is 0, `scl_low` is 0, `phase_tick` is 0 and `hs_mode` is 0.
- R2: The prescaler exponent is the number of single-bit right shifts applied while the ratio is 16 or more. It is placed in `timing_word[3:0]`.
- R3: The mantissa is the ratio left after shifting, plus one if any shifted-out bit was 1.
- R4: The low count is (mantissa >> 1) − 1, placed in `timing_word[15:12]`. The high count is mantissa − low count − 2, placed in `timing_word[19:16]`.
- R5: Every bit of `timing_word` outside fields 19:16, 15:12 and 3:0 equals the same bit of 0x77700300 whenever a word has been loaded.
- R6: A ratio of 0 or 1 is encoded as if it were 2.
- R7: `timing_word` is updated one clock after an accepted `start`. It stays unchanged until the next accepted `start`, whatever `ratio` does in between.
- R8: After an accepted `start`, `scl_low` is 1 for (low count + 1)·2^exponent cycles and then 0 for (high count + 1)·2^exponent cycles. This pattern repeats.
- R9: `phase_tick` is a one-cycle pulse in the first cycle of every low-to-high or high-to-low phase change while running.
- R10: After `stop`, `scl_low` is 0 and `phase_tick` stays 0 until the next accepted `start`.
- R11: When `start` and `stop` are high in the same cycle, `stop` wins. The strobe stops the sequencer and leaves `timing_word` unchanged.
- R12: `hs_mode` takes the value of `hs_en` at each accepted `start` and holds it until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio | input | RATIO_W | Requested peripheral-to-bus clock ratio |
| hs_en | input | 1 | High-speed selection, sampled at start |
| start | input | 1 | Strobe: encode ratio and (re)start the sequencer |
| stop | input | 1 | Strobe: halt the sequencer, release SCL high |
| timing_word | output | 32 | Encoded timing control word |
| hs_mode | output | 1 | Captured high-speed selection |
| scl_low | output | 1 | 1 during the SCL low phase |
| phase_tick | output | 1 | Pulse in the first cycle of a new phase |

## Verification
The bench builds the block with its default 16-bit ratio input. This width reaches exponents up to twelve, so the test ratios can cover several cases: no shifting (10, 15), a single shift with and without rounding (16, 17), several shifts where rounding carries the mantissa to sixteen (250, 1000), and the clamped ratios below two. For each ratio the bench measures the low and high phase lengths over a full period, including a prescaled case where each count spans 64 clocks. It also checks the start/stop collision and that the word is held while the ratio input changes.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  localparam int WORD_W  = 32;
  localparam int FLD_W   = 4;
  localparam int HI_LSB  = 16;
  localparam int LO_LSB  = 12;
  localparam int EXP_LSB = 0;
  localparam int MANT_LIM = 16;

  // constant setup/hold and timing fields outside the three computed ones
  localparam logic [WORD_W-1:0] FIXED_BITS = 32'h7770_0300;
  localparam logic [WORD_W-1:0] FIELD_MASK =
    ({{(WORD_W-FLD_W){1'b0}}, {FLD_W{1'b1}}} << HI_LSB) |
    ({{(WORD_W-FLD_W){1'b0}}, {FLD_W{1'b1}}} << LO_LSB) |
    ({{(WORD_W-FLD_W){1'b0}}, {FLD_W{1'b1}}} << EXP_LSB);

  typedef struct packed {
    logic [FLD_W-1:0] hi_cnt;
    logic [FLD_W-1:0] lo_cnt;
    logic [FLD_W-1:0] exp;
  } scl_fields_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  function automatic logic [WORD_W-1:0] pack_word(scl_fields_t f);
    logic [WORD_W-1:0] w;
    w = FIXED_BITS & ~FIELD_MASK;
    w = w | ({{(WORD_W-FLD_W){1'b0}}, f.hi_cnt} << HI_LSB);
    w = w | ({{(WORD_W-FLD_W){1'b0}}, f.lo_cnt} << LO_LSB);
    w = w | ({{(WORD_W-FLD_W){1'b0}}, f.exp}    << EXP_LSB);
    return w;
  endfunction

endpackage

// File: rtl/scl_div_encoder.sv
module scl_div_encoder
  import scl_timing_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic [RATIO_W-1:0] ratio,
  output scl_fields_t        fields
);

  localparam int MANT_W = FLD_W + 1;

  logic [RATIO_W-1:0] work;
  logic               rnd;
  logic [FLD_W-1:0]   exp_cnt;
  logic [MANT_W-1:0]  mant;
  logic [MANT_W-1:0]  lo5;
  logic [MANT_W-1:0]  hi5;

  always_comb begin
    work    = (ratio < RATIO_W'(2)) ? RATIO_W'(2) : ratio;
    rnd     = 1'b0;
    exp_cnt = '0;
    for (int i = 0; i < RATIO_W; i++) begin
      if (work >= RATIO_W'(MANT_LIM)) begin
        rnd     = rnd | work[0];
        work    = work >> 1;
        exp_cnt = exp_cnt + 1'b1;
      end
    end
    mant = {1'b0, work[FLD_W-1:0]} + {{FLD_W{1'b0}}, rnd};
    lo5  = (mant >> 1) - MANT_W'(1);
    hi5  = mant - lo5 - MANT_W'(2);
  end

  assign fields.exp    = exp_cnt;
  assign fields.lo_cnt = lo5[FLD_W-1:0];
  assign fields.hi_cnt = hi5[FLD_W-1:0];

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int CNT_W = 16,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [EXP_W-1:0] exp,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] wrap_at;

  assign wrap_at = (CNT_W'(1) << exp) - CNT_W'(1);
  assign tick    = en & ~clr & (cnt_q == wrap_at);

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !en)  cnt_d = '0;
    else if (tick)   cnt_d = '0;
    else             cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             halt,
  input  logic             tick,
  input  logic [FLD_W-1:0] lo_cnt,
  input  logic [FLD_W-1:0] hi_cnt,
  output logic             scl_low,
  output logic             phase_tick,
  output logic             running
);

  scl_phase_e       st_q, st_d;
  logic [FLD_W-1:0] cnt_q, cnt_d;
  logic             ptk_q, ptk_d;
  logic [FLD_W-1:0] limit;

  assign limit = (st_q == PH_LOW) ? lo_cnt : hi_cnt;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    ptk_d = 1'b0;
    if (halt) begin
      st_d  = PH_IDLE;
      cnt_d = '0;
    end else if (restart) begin
      st_d  = PH_LOW;
      cnt_d = '0;
    end else if (tick && st_q != PH_IDLE) begin
      if (cnt_q == limit) begin
        st_d  = (st_q == PH_LOW) ? PH_HIGH : PH_LOW;
        cnt_d = '0;
        ptk_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
      ptk_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ptk_q <= ptk_d;
    end
  end

  assign scl_low    = (st_q == PH_LOW);
  assign running    = (st_q != PH_IDLE);
  assign phase_tick = ptk_q;

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               hs_en,
  input  logic               start,
  input  logic               stop,
  output logic [31:0]        timing_word,
  output logic               hs_mode,
  output logic               scl_low,
  output logic               phase_tick
);

  localparam int CNT_W = RATIO_W;

  scl_fields_t enc_fields;
  scl_fields_t fld_q;
  logic [WORD_W-1:0] word_q;
  logic        hs_q;
  logic        load;
  logic        tick;
  logic        running;

  assign load = start & ~stop;

  scl_div_encoder #(.RATIO_W(RATIO_W)) u_enc (
    .ratio  (ratio),
    .fields (enc_fields)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q  <= '0;
      word_q <= '0;
      hs_q   <= 1'b0;
    end else if (load) begin
      fld_q  <= enc_fields;
      word_q <= pack_word(enc_fields);
      hs_q   <= hs_en;
    end
  end

  scl_prescaler #(.CNT_W(CNT_W), .EXP_W(FLD_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load | stop),
    .en    (running),
    .exp   (fld_q.exp),
    .tick  (tick)
  );

  scl_phase_ctrl u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (load),
    .halt       (stop),
    .tick       (tick),
    .lo_cnt     (fld_q.lo_cnt),
    .hi_cnt     (fld_q.hi_cnt),
    .scl_low    (scl_low),
    .phase_tick (phase_tick),
    .running    (running)
  );

  assign timing_word = word_q;
  assign hs_mode     = hs_q;

endmodule

// File: rtl/scl_timing_gen_checker.sv
module scl_timing_gen_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        stop,
  input logic [31:0] timing_word,
  input logic        scl_low,
  input logic        phase_tick,
  input logic        running
);

  logic load;
  assign load = start & ~stop;

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(timing_word)); // R7

  AST_FIXED_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((timing_word & ~32'h000F_F00F) == 32'h7770_0300)); // R5

  AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ({1'b0, timing_word[19:16]} + {1'b0, timing_word[15:12]} <= 5'd14)); // R4

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!scl_low && !phase_tick && !running)); // R10

  AST_TICK_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !$past(load)) |->
      (phase_tick == (scl_low != $past(scl_low)))); // R9

  AST_LOW_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    scl_low |-> running); // R10

endmodule

bind scl_timing_gen scl_timing_gen_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .stop        (stop),
  .timing_word (timing_word),
  .scl_low     (scl_low),
  .phase_tick  (phase_tick),
  .running     (running)
);

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RW = 16;

  logic          clk;
  logic          rst_n;
  logic [RW-1:0] ratio;
  logic          hs_en;
  logic          start;
  logic          stop;
  logic [31:0]   timing_word;
  logic          hs_mode;
  logic          scl_low;
  logic          phase_tick;

  int n_checks;
  int n_fails;

  scl_timing_gen #(.RATIO_W(RW)) u_scl_timing_gen (
    .clk (clk), .rst_n (rst_n), .ratio (ratio), .hs_en (hs_en),
    .start (start), .stop (stop), .timing_word (timing_word),
    .hs_mode (hs_mode), .scl_low (scl_low), .phase_tick (phase_tick)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // reference model by leading-one position
  function automatic int ref_exp(input int r_in);
    int r, msb;
    r = (r_in < 2) ? 2 : r_in;
    msb = 0;
    for (int b = 0; b < 32; b++) if ((r >> b) & 1) msb = b;
    return (msb > 3) ? msb - 3 : 0;
  endfunction

  function automatic int ref_mant(input int r_in);
    int r, e, m;
    r = (r_in < 2) ? 2 : r_in;
    e = ref_exp(r_in);
    m = r >> e;
    if ((r & ((1 << e) - 1)) != 0) m = m + 1;
    return m;
  endfunction

  function automatic logic [31:0] ref_word(input int r_in);
    int e, m, lo, hi;
    e  = ref_exp(r_in);
    m  = ref_mant(r_in);
    lo = m / 2 - 1;
    hi = m - lo - 2;
    return 32'h7770_0300 | (32'(hi) << 16) | (32'(lo) << 12) | 32'(e);
  endfunction

  task automatic pulse(input bit s, input bit p);
    @(negedge clk);
    start = s;
    stop  = p;
    @(negedge clk);
    start = 1'b0;
    stop  = 1'b0;
  endtask

  task automatic t_reset();
    chk(timing_word == 32'h0, "R1 word", timing_word, 0);
    chk(scl_low == 1'b0, "R1 scl_low", scl_low, 0);
    chk(phase_tick == 1'b0, "R1 phase_tick", phase_tick, 0);
    chk(hs_mode == 1'b0, "R1 hs_mode", hs_mode, 0);
  endtask

  // start a ratio and measure one full low/high period
  task automatic t_case(input int r, input bit hs, input string req);
    int e, m, lo, hi, nlow, nhigh, guard;
    logic [31:0] w;
    w  = ref_word(r);
    e  = ref_exp(r);
    m  = ref_mant(r);
    lo = m / 2 - 1;
    hi = m - lo - 2;
    @(negedge clk);
    ratio = RW'(r);
    hs_en = hs;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(timing_word == w, {req, " R2 R3 R4 R5 R7 word"}, timing_word, w);
    chk(hs_mode == hs, "R12 hs_mode", hs_mode, hs);
    chk(scl_low == 1'b1, "R8 low after start", scl_low, 1);
    nlow = 1;
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (!scl_low || guard > 20000) break;
      nlow++;
    end
    chk(phase_tick == 1'b1, "R9 tick at high", phase_tick, 1);
    nhigh = 1;
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (scl_low || guard > 20000) break;
      chk(phase_tick == 1'b0, "R9 tick single", phase_tick, 0);
      nhigh++;
    end
    chk(phase_tick == 1'b1, "R9 tick at low", phase_tick, 1);
    chk(nlow == (lo + 1) << e, "R8 low length", nlow, (lo + 1) << e);
    chk(nhigh == (hi + 1) << e, "R8 high length", nhigh, (hi + 1) << e);
  endtask

  task automatic t_stop();
    bit bad;
    pulse(1'b0, 1'b1);
    bad = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (scl_low || phase_tick) bad = 1'b1;
      @(negedge clk);
    end
    chk(!bad, "R10 stopped stays released", bad, 0);
  endtask

  task automatic t_hold();
    logic [31:0] w0;
    w0 = timing_word;
    @(negedge clk);
    ratio = RW'(12345);
    hs_en = ~hs_en;
    repeat (5) @(negedge clk);
    chk(timing_word == w0, "R7 word held", timing_word, w0);
  endtask

  task automatic t_both();
    logic [31:0] w0;
    w0 = timing_word;
    @(negedge clk);
    ratio = RW'(40);
    start = 1'b1;
    stop  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    stop  = 1'b0;
    chk(timing_word == w0, "R11 word unchanged", timing_word, w0);
    repeat (20) @(negedge clk);
    chk(scl_low == 1'b0, "R11 stays stopped", scl_low, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    n_checks = 0;
    n_fails  = 0;
    rst_n = 1'b0;
    ratio = '0;
    hs_en = 1'b0;
    start = 1'b0;
    stop  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_case(10,   1'b0, "R2");
    t_case(15,   1'b1, "R4");
    t_case(16,   1'b0, "R2");
    t_case(17,   1'b0, "R3");
    t_case(250,  1'b1, "R3");
    t_case(1000, 1'b0, "R8");
    t_hold();
    t_stop();
    t_case(1,    1'b0, "R6");
    t_case(0,    1'b0, "R6");
    t_case(3,    1'b0, "R4");
    t_both();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule